// File: doc/BRIEF.md
# Multicart Configuration Register File with Mirroring Control

This block is the CPU-facing register file of a multi-game cartridge bank-switching controller. The CPU first writes a register-select code into a small select latch. It does this with a write anywhere in the 0x5000–0x5FFF window, and only data bits 7 and 0 are kept. Each later write anywhere in 0x8000–0xFFFF lands in the configuration register that the latch names. There are four such registers: a CHR bank, an inner PRG bank, a mode register and an outer bank. The mode, inner and outer values are presented as outputs to a separate PRG address generator.

The low two mode bits choose the nametable arrangement: one-screen lower page, one-screen upper page, vertical or horizontal. The block turns that choice into the console-RAM A10 select, using the PPU address. While a one-screen arrangement is active, a write to the CHR or inner PRG register also loads data bit 4 into mode bit 0. This lets software flip the visible screen page without rewriting the mode register. The 8 KiB CHR bank is joined to the low PPU address lines to form the CHR ROM address.

Top module: `mc_cfg_regs`

## Requirements
- R1: A write with CPU address bits 15:12 equal to 0x5 loads the select latch with data bits 7 and 0. The other data bits have no effect on which register later writes reach.
- R2: A write with CPU address bit 15 set goes to the register named by the select code {data7, data0}: 00 is CHR, 01 is inner PRG, 10 is mode, 11 is outer bank.
- R3: The CHR register keeps data bits 1:0, the inner PRG register keeps bits 3:0, and the mode and outer registers each keep bits 5:0.
- R4: On a write to the CHR or inner PRG register while mode bit 1 is 0, mode bit 0 takes data bit 4 and mode bits 5:1 are unchanged.
- R5: On a write to the CHR or inner PRG register while mode bit 1 is 1, the mode register is unchanged.
- R6: The mirroring output equals mode bits 1:0 (0 one-screen lower, 1 one-screen upper, 2 vertical, 3 horizontal). The console-RAM A10 output is 0, 1, PPU A10 or PPU A11 respectively.
- R7: A synchronous active-low reset sets the outer bank to 63 and the inner PRG bank to 15. It clears the CHR bank, the mode and the select latch to 0.
- R8: The CHR ROM address is {CHR bank[1:0], PPU A12:A0}.
- R9: Writes to addresses outside 0x5000–0x5FFF and 0x8000–0xFFFF change no register.
- R10: With the write strobe low, no register changes. A write takes effect on the clock edge at which the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cpuWr | input | 1 | CPU write strobe, sampled on the rising edge |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| ppuAddr | input | 14 | PPU address |
| chrAddr | output | 15 | CHR ROM address |
| ciramA10 | output | 1 | Console nametable RAM A10 select |
| mirrorMode | output | 2 | Active nametable arrangement |
| chrBank | output | 2 | CHR bank register |
| prgInner | output | 4 | Inner PRG bank register |
| prgMode | output | 6 | Mode register |
| outerBank | output | 6 | Outer bank register |

## Verification
Every register is visible at the ports one edge after the write that loads it. A wrong data field or a misrouted write therefore shows on the next sample. The select latch is hidden, so a wrong latch value shows only on the next write to the 0x8000–0xFFFF window, when a different register moves. A wrong mode bit 0 after a CHR or PRG write shows at once in the mirroring output. It also shows in the console-RAM A10 select, which is checked against the PPU address every cycle.

// File: rtl/mc_cfg_pkg.sv
package mc_cfg_pkg;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic selWr;
    logic chrWr;
    logic prgWr;
    logic modeWr;
    logic outerWr;
  } cfgStrobe_t;

  // Nametable arrangement, encoded as the low mode bits
  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  // Select codes {data7, data0}
  localparam logic [1:0] SEL_CHR   = 2'b00;
  localparam logic [1:0] SEL_PRG   = 2'b01;
  localparam logic [1:0] SEL_MODE  = 2'b10;
  localparam logic [1:0] SEL_OUTER = 2'b11;

  localparam logic [3:0] SEL_WINDOW = 4'h5;

endpackage

// File: rtl/mc_cfg_ctrl.sv
module mc_cfg_ctrl
  import mc_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output cfgStrobe_t        strobe
);

  localparam int NIB_LSB = ADDR_W - 4;

  logic       selHit;
  logic       bankHit;
  logic [1:0] selQ;

  assign selHit  = cpuWr && (cpuAddr[ADDR_W-1:NIB_LSB] == SEL_WINDOW);
  assign bankHit = cpuWr && cpuAddr[ADDR_W-1];

  // Select latch keeps only the outer data bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= 2'b00;
    end else if (selHit) begin
      selQ <= {cpuData[DATA_W-1], cpuData[0]};
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.selWr = selHit;
    if (bankHit) begin
      unique case (selQ)
        SEL_CHR:   strobe.chrWr   = 1'b1;
        SEL_PRG:   strobe.prgWr   = 1'b1;
        SEL_MODE:  strobe.modeWr  = 1'b1;
        SEL_OUTER: strobe.outerWr = 1'b1;
        default:   strobe         = '0;
      endcase
    end
  end

endmodule

// File: rtl/mc_cfg_dp.sv
module mc_cfg_dp
  import mc_cfg_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CHR_W   = 2,
  parameter int PRG_W   = 4,
  parameter int MODE_W  = 6,
  parameter int OUTER_W = 6,
  parameter int PAGE_BIT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic [DATA_W-1:0]  cpuData,
  output logic [CHR_W-1:0]   chrQ,
  output logic [PRG_W-1:0]   prgQ,
  output logic [MODE_W-1:0]  modeQ,
  output logic [OUTER_W-1:0] outerQ
);

  localparam logic [PRG_W-1:0]   PRG_RST   = '1;
  localparam logic [OUTER_W-1:0] OUTER_RST = '1;

  logic pageWr;
  assign pageWr = (strobe.chrWr || strobe.prgWr) && !modeQ[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chrQ <= '0;
    end else if (strobe.chrWr) begin
      chrQ <= cpuData[CHR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prgQ <= PRG_RST;
    end else if (strobe.prgWr) begin
      prgQ <= cpuData[PRG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outerQ <= OUTER_RST;
    end else if (strobe.outerWr) begin
      outerQ <= cpuData[OUTER_W-1:0];
    end
  end

  // Full mode load, or page-bit update while a one-screen layout is active
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (strobe.modeWr) begin
      modeQ <= cpuData[MODE_W-1:0];
    end else if (pageWr) begin
      modeQ[0] <= cpuData[PAGE_BIT];
    end
  end

endmodule

// File: rtl/mc_cfg_mirror.sv
module mc_cfg_mirror
  import mc_cfg_pkg::*;
#(
  parameter int PPU_AW = 14
) (
  input  logic [1:0]        layout,
  input  logic [PPU_AW-1:0] ppuAddr,
  output mirror_e           mirrorSel,
  output logic              ciramA10
);

  assign mirrorSel = mirror_e'(layout);

  always_comb begin
    unique case (mirrorSel)
      MIR_ONE_LO: ciramA10 = 1'b0;
      MIR_ONE_HI: ciramA10 = 1'b1;
      MIR_VERT:   ciramA10 = ppuAddr[10];
      MIR_HORZ:   ciramA10 = ppuAddr[11];
      default:    ciramA10 = 1'b0;
    endcase
  end

endmodule

// File: rtl/mc_cfg_regs.sv
module mc_cfg_regs
  import mc_cfg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int PPU_AW  = 14,
  parameter int CHR_W   = 2,
  parameter int PRG_W   = 4,
  parameter int MODE_W  = 6,
  parameter int OUTER_W = 6,
  parameter int PAGE_LO = 13,
  parameter int CHR_AW  = CHR_W + PAGE_LO
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuWr,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuData,
  input  logic [PPU_AW-1:0]  ppuAddr,
  output logic [CHR_AW-1:0]  chrAddr,
  output logic               ciramA10,
  output logic [1:0]         mirrorMode,
  output logic [CHR_W-1:0]   chrBank,
  output logic [PRG_W-1:0]   prgInner,
  output logic [MODE_W-1:0]  prgMode,
  output logic [OUTER_W-1:0] outerBank
);

  cfgStrobe_t strobe;
  mirror_e    mirrorSel;

  mc_cfg_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuWr   (cpuWr),
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .strobe  (strobe)
  );

  mc_cfg_dp #(
    .DATA_W  (DATA_W),
    .CHR_W   (CHR_W),
    .PRG_W   (PRG_W),
    .MODE_W  (MODE_W),
    .OUTER_W (OUTER_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cpuData (cpuData),
    .chrQ    (chrBank),
    .prgQ    (prgInner),
    .modeQ   (prgMode),
    .outerQ  (outerBank)
  );

  mc_cfg_mirror #(
    .PPU_AW (PPU_AW)
  ) u_mirror (
    .layout    (prgMode[1:0]),
    .ppuAddr   (ppuAddr),
    .mirrorSel (mirrorSel),
    .ciramA10  (ciramA10)
  );

  assign mirrorMode = mirrorSel;
  assign chrAddr    = {chrBank, ppuAddr[PAGE_LO-1:0]};

endmodule

// File: rtl/mc_cfg_regs_chk.sv
module mc_cfg_regs_chk
  import mc_cfg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cpuWr,
  input logic [7:0] cpuData,
  input logic [13:0] ppuAddr,
  input logic       ciramA10,
  input cfgStrobe_t strobe,
  input logic [5:0] prgMode,
  input logic [3:0] prgInner,
  input logic [5:0] outerBank,
  input logic [1:0] chrBank
);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selWr, strobe.chrWr, strobe.prgWr, strobe.modeWr, strobe.outerWr}));

  // R4
  page_bit_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.chrWr || strobe.prgWr) && !prgMode[1]) |=>
      (prgMode[0] == $past(cpuData[4]) && prgMode[5:1] == $past(prgMode[5:1])));

  // R5
  page_bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.chrWr || strobe.prgWr) && prgMode[1]) |=> $stable(prgMode));

  // R6
  vert_a10_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prgMode[1:0] == 2'd2) |-> (ciramA10 == ppuAddr[10]));

  // R6
  horz_a10_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prgMode[1:0] == 2'd3) |-> (ciramA10 == ppuAddr[11]));

  // R7
  reset_value_chk: assert property (@(posedge clk)
    !rstN |=> (outerBank == 6'd63 && prgInner == 4'd15 && chrBank == 2'd0 && prgMode == 6'd0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWr |=> ($stable(outerBank) && $stable(prgInner) && $stable(chrBank) && $stable(prgMode)));

endmodule

bind mc_cfg_regs mc_cfg_regs_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuWr     (cpuWr),
  .cpuData   (cpuData),
  .ppuAddr   (ppuAddr),
  .ciramA10  (ciramA10),
  .strobe    (strobe),
  .prgMode   (prgMode),
  .prgInner  (prgInner),
  .outerBank (outerBank),
  .chrBank   (chrBank)
);

// File: tb/mc_cfg_regs_tb.sv
module mc_cfg_regs_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWr = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic [13:0] ppuAddr = '0;
  logic [14:0] chrAddr;
  logic        ciramA10;
  logic [1:0]  mirrorMode;
  logic [1:0]  chrBank;
  logic [3:0]  prgInner;
  logic [5:0]  prgMode;
  logic [5:0]  outerBank;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  // Reference state
  int refSel = 0, refChr = 0, refPrg = 15, refMode = 0, refOuter = 63;

  always #4 clk = ~clk;

  mc_cfg_regs u_dut (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .ppuAddr(ppuAddr), .chrAddr(chrAddr), .ciramA10(ciramA10), .mirrorMode(mirrorMode),
    .chrBank(chrBank), .prgInner(prgInner), .prgMode(prgMode), .outerBank(outerBank)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    started <= 1;
    if (!rstN) begin
      refSel = 0; refChr = 0; refPrg = 15; refMode = 0; refOuter = 63;
    end else if (cpuWr) begin
      if (cpuAddr >= 16'h5000 && cpuAddr <= 16'h5FFF) begin
        refSel = cpuData & 8'h81;
      end else if (cpuAddr >= 16'h8000) begin
        if (refSel == 'h00 || refSel == 'h01) begin
          if (refSel == 'h00) refChr = cpuData % 4;
          else refPrg = cpuData % 16;
          if ((refMode & 2) == 0) refMode = (refMode & 'h3E) | ((cpuData >> 4) & 1);
        end else if (refSel == 'h80) refMode = cpuData % 64;
        else refOuter = cpuData % 64;
      end
    end
  end

  function automatic int expA10(int m, logic [13:0] p);
    case (m % 4)
      0: return 0;
      1: return 1;
      2: return int'(p[10]);
      default: return int'(p[11]);
    endcase
  endfunction

  // Per-cycle comparison away from the edge
  always @(negedge clk) begin
    #1;
    if (started && !done) begin
      check("R3 chr", chrBank, refChr);
      check("R2 prg", prgInner, refPrg);
      check("R4 mode", prgMode, refMode);
      check("R2 outer", outerBank, refOuter);
      check("R6 mirror", mirrorMode, refMode % 4);
      check("R6 a10", ciramA10, expA10(refMode, ppuAddr));
      check("R8 chrAddr", chrAddr, refChr * 8192 + ppuAddr % 8192);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      ppuAddr = 14'($urandom);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWr = 1'b1; cpuAddr = a; cpuData = d;
    @(negedge clk);
    cpuWr = 1'b0; cpuAddr = 16'h0000; cpuData = 8'h00;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R7 reset state
    check("R7 outer", outerBank, 63);
    check("R7 prg", prgInner, 15);
    check("R7 chr", chrBank, 0);
    check("R7 mode", prgMode, 0);
    rstN = 1'b1;

    // R1 latch masking: 0xFF selects outer
    wr(16'h5ABC, 8'hFF);
    wr(16'hC000, 8'hEA);
    check("R1 outer via masked select", outerBank, 6'h2A);
    // R3 field width on mode
    wr(16'h5000, 8'h80);
    wr(16'h8000, 8'hFE);
    check("R3 mode width", prgMode, 6'h3E);
    // R5 mode bit1 set: PRG write leaves mode
    wr(16'h5FFF, 8'h7F);
    wr(16'hFFFF, 8'h17);
    check("R5 mode held", prgMode, 6'h3E);
    check("R3 prg width", prgInner, 7);
    // R4 one-screen: page bit follows data4
    wr(16'h5000, 8'h80);
    wr(16'h9000, 8'h00);
    wr(16'h5000, 8'h00);
    wr(16'hA000, 8'h13);
    check("R4 page bit set", prgMode, 1);
    check("R6 one-screen upper", ciramA10, 1);
    check("R3 chr width", chrBank, 3);
    wr(16'hA000, 8'h02);
    check("R4 page bit clear", prgMode, 0);
    // R9 writes outside the windows
    wr(16'h6000, 8'hFF);
    wr(16'h4FFF, 8'h81);
    wr(16'h7FFF, 8'h01);
    wr(16'h8000, 8'h11);
    check("R9 latch untouched", chrBank, 1);
    // R6 vertical and horizontal
    wr(16'h5000, 8'h80);
    wr(16'h8000, 8'h02);
    repeat (8) @(negedge clk);
    wr(16'h8000, 8'h03);
    repeat (8) @(negedge clk);
    // R10 idle cycles
    repeat (5) @(negedge clk);
    #2;
    check("R10 idle mode", prgMode, 3);

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      case ($urandom % 4)
        0: a = 16'h5000 | 16'($urandom % 4096);
        1: a = 16'($urandom % 32768);
        default: a = 16'h8000 | 16'($urandom % 32768);
      endcase
      wr(a, 8'($urandom));
    end
    // R7 reset again mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; #2;
    check("R7 reapplied outer", outerBank, 63);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule